// File: doc/BRIEF.md
# Address Decoder Commit Register Bank

This block holds a small set of host-address range decoders and runs the commit handshake for each of them. Software reaches it through a plain 32-bit register port. Each decoder has a control word, a 64-bit base, a 64-bit size and a 64-bit routing word. Each 64-bit value is split into a low and a high 32-bit register. On a switch-style port the routing word holds up to eight one-byte target port IDs. On an endpoint-style port the same slot holds a 64-bit skip value. One capability word at the start of the map tells software how many decoders exist and which interleave options the block accepts.

Software programs a decoder and then sets its commit request bit. A fixed number of cycles later the decoder reports either committed or commit error. The block reports an error for any of these four cases:
- the decoder below it is not committed;
- the size is zero;
- the size is not an exact multiple of the interleave way count;
- the way encoding is one the capability word does not advertise.

Clearing the request bit takes the decoder back to uncommitted. A decoder that is committed with its lock bit set ignores every write until reset. The memory datapath and the actual address routing are outside this block.

Top module: `addr_decoder_bank`

## Requirements
- R1: After reset every decoder is uncommitted with no error, and its control word, base, size and routing registers all read as zero.
- R2: The capability word at byte address 0x00 reads as follows. Bits 3:0 hold the decoder count and bits 7:4 hold the target count. Bit 8 flags extra interleave address bits 11:8 and bit 9 flags extra bits 14:12. Bit 10 flags 3/6/12-way support and bit 11 flags 16-way support. All other bits read as zero.
- R3: Writing the control word of an idle decoder with its commit request bit (bit 9) set raises exactly one of committed (bit 10, and `dec_committed`) or error (bit 11, and `dec_error`), exactly EVAL_CYCLES clock edges after the write edge.
- R4: A commit request on decoder m+1 ends in error when decoder m is not committed at evaluation time. Decoder 0 has no such condition.
- R5: Writing the control word with bit 9 clear while a decoder is committing, committed or in error returns it to idle. This clears bits 9, 10 and 11 and keeps the base, size, routing word and control fields.
- R6: A commit with a size of zero, or with a size that is not an exact multiple of the way count, ends in error.
- R7: The way field (control bits 7:4) encodes the way count as follows:
  - 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 ways;
  - 8, 9 and 10 mean 3, 6 and 12 ways;
  - any other value is invalid.
  An invalid value, or one the capability word does not advertise, ends the commit in error.
- R8: Each 64-bit value reads back exactly as written through its low and high registers. In the routing word, target entry k sits in bits 8k+7:8k.
- R9: While a decoder is committed with its lock bit (control bit 8) set, writes to its control, base, size and routing registers have no effect, including a write that clears bit 9.
- R10: While a decoder is not idle, a control write with bit 9 set leaves granularity (bits 3:0), ways (bits 7:4), lock (bit 8) and host-only (bit 12) unchanged.
- R11: Decoder d (counting from 0) occupies byte addresses 0x20·(d+1) + 4·k. The word index k selects the register as follows:
  - 0 is the control word;
  - 1 and 2 are the base low and high halves;
  - 3 and 4 are the size low and high halves;
  - 5 and 6 are the routing word low and high halves.
  A read returns its data with `rd_valid` one cycle after the request. Any unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| dec_committed | output | NUM_DEC | Per-decoder committed status |
| dec_error | output | NUM_DEC | Per-decoder commit error status |

## Verification
The bench checks the commit order rule in two directions. It commits decoder 1 before decoder 0, which must fail; a design that skipped this check would commit decoder 1. It then commits a locked decoder above a decoder that it later releases. It tries a zero size, a size that does not divide by three under 3-way interleave, and an unadvertised 16-way encoding. A design with a wrong size or way check would show committed where error is expected. The bench also writes a locked, committed decoder's base and control words and releases a committed decoder. A broken lock would change those values, and a broken release would leave the status bits set or wipe the programmed size.

// File: rtl/adb_pkg.sv
package adb_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_BUSY,
        SLOT_DONE,
        SLOT_FAIL
    } slot_state_e;

    typedef enum logic [2:0] {
        OFS_CTRL    = 3'd0,
        OFS_BASE_LO = 3'd1,
        OFS_BASE_HI = 3'd2,
        OFS_SIZE_LO = 3'd3,
        OFS_SIZE_HI = 3'd4,
        OFS_RTE_LO  = 3'd5,
        OFS_RTE_HI  = 3'd6,
        OFS_NONE    = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic       host;
        logic       lock;
        logic [3:0] ways;
        logic [3:0] gran;
    } ctrl_cfg_t;

    localparam int CTL_REQ_BIT  = 9;
    localparam int CTL_HOST_BIT = 12;
    localparam int CTL_LOCK_BIT = 8;

endpackage

// File: rtl/adb_cfg_check.sv
module adb_cfg_check #(
    parameter bit CAP_3_6_12 = 1'b1,
    parameter bit CAP_16WAY  = 1'b0
) (
    input  logic [3:0]  ways,
    input  logic [63:0] size,
    input  logic        prev_ok,
    output logic        cfg_ok
);

    logic [2:0]  shift_amt;
    logic        three_fac;
    logic        way_ok;
    logic [63:0] low_mask;
    logic        mult_ok;

    always_comb begin
        shift_amt = 3'd0;
        three_fac = 1'b0;
        way_ok    = 1'b1;
        case (ways)
            4'd0:  shift_amt = 3'd0;
            4'd1:  shift_amt = 3'd1;
            4'd2:  shift_amt = 3'd2;
            4'd3:  shift_amt = 3'd3;
            4'd4:  begin shift_amt = 3'd4; way_ok = CAP_16WAY; end
            4'd8:  begin shift_amt = 3'd0; three_fac = 1'b1; way_ok = CAP_3_6_12; end
            4'd9:  begin shift_amt = 3'd1; three_fac = 1'b1; way_ok = CAP_3_6_12; end
            4'd10: begin shift_amt = 3'd2; three_fac = 1'b1; way_ok = CAP_3_6_12; end
            default: way_ok = 1'b0;
        endcase
        low_mask = (64'd1 << shift_amt) - 64'd1;
        mult_ok  = ((size & low_mask) == 64'd0) && (!three_fac || ((size % 64'd3) == 64'd0));
        cfg_ok   = prev_ok && way_ok && (size != 64'd0) && mult_ok;
    end

endmodule

// File: rtl/adb_decoder_slot.sv
module adb_decoder_slot
    import adb_pkg::*;
#(
    parameter int EVAL_CYCLES = 2,
    parameter bit CAP_3_6_12  = 1'b1,
    parameter bit CAP_16WAY   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_ofs,
    input  logic [31:0] wr_data,
    input  logic        prev_committed,
    output logic [31:0] ctrl_word,
    output logic [63:0] base_val,
    output logic [63:0] size_val,
    output logic [63:0] rte_val,
    output logic        committed,
    output logic        error,
    output logic        busy,
    output logic        locked
);

    localparam int CNT_W = $clog2(EVAL_CYCLES + 1);

    typedef struct packed {
        slot_state_e      state;
        logic [CNT_W-1:0] cnt;
        ctrl_cfg_t        cfg;
        logic             req;
        logic [63:0]      base;
        logic [63:0]      size;
        logic [63:0]      rte;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  cfg_ok;
    logic  frozen;

    adb_cfg_check #(
        .CAP_3_6_12(CAP_3_6_12),
        .CAP_16WAY (CAP_16WAY)
    ) i_cfg_check (
        .ways   (slot_q.cfg.ways),
        .size   (slot_q.size),
        .prev_ok(prev_committed),
        .cfg_ok (cfg_ok)
    );

    always_comb begin
        slot_d = slot_q;
        frozen = (slot_q.state == SLOT_DONE) && slot_q.cfg.lock;

        if (slot_q.state == SLOT_BUSY) begin
            if (slot_q.cnt == '0) begin
                slot_d.state = cfg_ok ? SLOT_DONE : SLOT_FAIL;
            end else begin
                slot_d.cnt = slot_q.cnt - 1'b1;
            end
        end

        if (wr_en && !frozen) begin
            case (reg_ofs_e'(wr_ofs))
                OFS_CTRL: begin
                    if (slot_q.state == SLOT_IDLE) begin
                        slot_d.cfg.gran = wr_data[3:0];
                        slot_d.cfg.ways = wr_data[7:4];
                        slot_d.cfg.lock = wr_data[CTL_LOCK_BIT];
                        slot_d.cfg.host = wr_data[CTL_HOST_BIT];
                        slot_d.req      = wr_data[CTL_REQ_BIT];
                        if (wr_data[CTL_REQ_BIT]) begin
                            slot_d.state = SLOT_BUSY;
                            slot_d.cnt   = CNT_W'(EVAL_CYCLES - 1);
                        end
                    end else if (!wr_data[CTL_REQ_BIT]) begin
                        slot_d.state = SLOT_IDLE;
                        slot_d.req   = 1'b0;
                        slot_d.cnt   = '0;
                    end
                end
                OFS_BASE_LO: slot_d.base[31:0]  = wr_data;
                OFS_BASE_HI: slot_d.base[63:32] = wr_data;
                OFS_SIZE_LO: slot_d.size[31:0]  = wr_data;
                OFS_SIZE_HI: slot_d.size[63:32] = wr_data;
                OFS_RTE_LO:  slot_d.rte[31:0]   = wr_data;
                OFS_RTE_HI:  slot_d.rte[63:32]  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{state: SLOT_IDLE, default: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign committed = (slot_q.state == SLOT_DONE);
    assign error     = (slot_q.state == SLOT_FAIL);
    assign busy      = (slot_q.state == SLOT_BUSY);
    assign locked    = slot_q.cfg.lock;
    assign base_val  = slot_q.base;
    assign size_val  = slot_q.size;
    assign rte_val   = slot_q.rte;
    assign ctrl_word = {19'd0, slot_q.cfg.host, error, committed, slot_q.req,
                        slot_q.cfg.lock, slot_q.cfg.ways, slot_q.cfg.gran};

endmodule

// File: rtl/adb_read_mux.sv
module adb_read_mux
    import adb_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               cap_word,
    input  logic [NUM_DEC-1:0][31:0]  ctrl_words,
    input  logic [NUM_DEC-1:0][63:0]  bases,
    input  logic [NUM_DEC-1:0][63:0]  sizes,
    input  logic [NUM_DEC-1:0][63:0]  rtes,
    output logic [31:0]               data
);

    localparam int SEL_W = ADDR_W - 5;

    logic [SEL_W-1:0] sel;
    logic [2:0]       ofs;
    logic [1:0]       unused_lsb;

    assign sel        = addr[ADDR_W-1:5];
    assign ofs        = addr[4:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        data = 32'd0;
        if (sel == '0) begin
            if (ofs == 3'd0) data = cap_word;
        end else begin
            for (int k = 0; k < NUM_DEC; k++) begin
                if (int'(sel) == k + 1) begin
                    case (reg_ofs_e'(ofs))
                        OFS_CTRL:    data = ctrl_words[k];
                        OFS_BASE_LO: data = bases[k][31:0];
                        OFS_BASE_HI: data = bases[k][63:32];
                        OFS_SIZE_LO: data = sizes[k][31:0];
                        OFS_SIZE_HI: data = sizes[k][63:32];
                        OFS_RTE_LO:  data = rtes[k][31:0];
                        OFS_RTE_HI:  data = rtes[k][63:32];
                        default:     data = 32'd0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/addr_decoder_bank.sv
module addr_decoder_bank #(
    parameter int NUM_DEC     = 4,
    parameter int TGT_CNT     = 8,
    parameter int EVAL_CYCLES = 2,
    parameter int ADDR_W      = 8,
    parameter bit CAP_3_6_12  = 1'b1,
    parameter bit CAP_16WAY   = 1'b0,
    parameter bit IA_11_8     = 1'b1,
    parameter bit IA_14_12    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [NUM_DEC-1:0] dec_committed,
    output logic [NUM_DEC-1:0] dec_error
);

    localparam int SEL_W = ADDR_W - 5;
    localparam logic [31:0] CAP_WORD = {20'd0, CAP_16WAY, CAP_3_6_12, IA_14_12, IA_11_8,
                                        4'(TGT_CNT), 4'(NUM_DEC)};

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [NUM_DEC-1:0][31:0] ctrl_words;
    logic [NUM_DEC-1:0][63:0] bases;
    logic [NUM_DEC-1:0][63:0] sizes;
    logic [NUM_DEC-1:0][63:0] rtes;
    logic [NUM_DEC-1:0]       dec_busy;
    logic [NUM_DEC-1:0]       dec_locked;
    logic [NUM_DEC-1:0]       prev_ok;
    logic [SEL_W-1:0]         wr_sel;
    logic [31:0]              mux_data;

    assign wr_sel = req_addr[ADDR_W-1:5];

    generate
        for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
            logic slot_wr;
            if (g == 0) begin : g_first
                assign prev_ok[g] = 1'b1;
            end else begin : g_rest
                assign prev_ok[g] = dec_committed[g-1];
            end
            assign slot_wr = req_valid && req_write && (int'(wr_sel) == g + 1);

            adb_decoder_slot #(
                .EVAL_CYCLES(EVAL_CYCLES),
                .CAP_3_6_12 (CAP_3_6_12),
                .CAP_16WAY  (CAP_16WAY)
            ) i_slot (
                .clk           (clk),
                .rst_n         (rst_n),
                .wr_en         (slot_wr),
                .wr_ofs        (req_addr[4:2]),
                .wr_data       (req_wdata),
                .prev_committed(prev_ok[g]),
                .ctrl_word     (ctrl_words[g]),
                .base_val      (bases[g]),
                .size_val      (sizes[g]),
                .rte_val       (rtes[g]),
                .committed     (dec_committed[g]),
                .error         (dec_error[g]),
                .busy          (dec_busy[g]),
                .locked        (dec_locked[g])
            );
        end
    endgenerate

    adb_read_mux #(
        .NUM_DEC(NUM_DEC),
        .ADDR_W (ADDR_W)
    ) i_read_mux (
        .addr      (req_addr),
        .cap_word  (CAP_WORD),
        .ctrl_words(ctrl_words),
        .bases     (bases),
        .sizes     (sizes),
        .rtes      (rtes),
        .data      (mux_data)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = req_valid && !req_write;
        rd_d.data  = (req_valid && !req_write) ? mux_data : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

endmodule

// File: rtl/adb_checker.sv
module adb_checker #(
    parameter int NUM_DEC        = 4,
    parameter int MAX_COMMIT_CYC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DEC-1:0] committed,
    input logic [NUM_DEC-1:0] error,
    input logic [NUM_DEC-1:0] busy,
    input logic [NUM_DEC-1:0] locked
);

    generate
        for (genvar g = 0; g < NUM_DEC; g++) begin : g_chk
            int busy_run_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) busy_run_q <= 0;
                else        busy_run_q <= busy[g] ? busy_run_q + 1 : 0;
            end

            AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({busy[g], committed[g], error[g]})); // R3

            AST_COMMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                busy_run_q <= MAX_COMMIT_CYC); // R3

            AST_ERROR_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(error[g]) |-> $past(busy[g])); // R3

            AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (committed[g] && locked[g]) |=> committed[g]); // R9

            if (g > 0) begin : g_order
                AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(committed[g]) |-> $past(committed[g-1])); // R4
            end
        end
    endgenerate

endmodule

bind addr_decoder_bank adb_checker #(
    .NUM_DEC       (NUM_DEC),
    .MAX_COMMIT_CYC(EVAL_CYCLES)
) i_adb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .committed(dec_committed),
    .error    (dec_error),
    .busy     (dec_busy),
    .locked   (dec_locked)
);

// File: tb/test_addr_decoder_bank.sv
`timescale 1ns/1ps
module test_addr_decoder_bank;

    localparam int NUM_DEC = 4;
    localparam int EVAL    = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [7:0]         req_addr = '0;
    logic [31:0]        req_wdata = '0;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [NUM_DEC-1:0] dec_committed;
    logic [NUM_DEC-1:0] dec_error;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    addr_decoder_bank #(.NUM_DEC(NUM_DEC), .EVAL_CYCLES(EVAL)) i_addr_decoder_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .dec_committed(dec_committed), .dec_error(dec_error)
    );

    function automatic logic [7:0] ra(int d, int k);
        return 8'((d + 1) * 32 + k * 4);
    endfunction

    function automatic logic [31:0] cw(int gran, int ways, bit lock, bit req, bit host);
        return {19'd0, host, 2'b00, req, lock, 4'(ways), 4'(gran)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard when read data appears
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read data", rd_data, 32'hxxxx_xxxx);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rd_data, e);
            end
        end
    end

    // commit request then wait for status; expect ok (1) or error (0)
    task automatic commit(int d, logic [31:0] ctrl, bit exp_ok, string tag);
        int n;
        wr(ra(d, 0), ctrl);
        n = 0;
        while (!(dec_committed[d] || dec_error[d]) && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " status"}, {30'd0, dec_error[d], dec_committed[d]},
            exp_ok ? 32'd1 : 32'd2);
        chk("R3 commit latency", 32'(n), 32'(EVAL));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset committed", 32'(dec_committed), 32'd0);
        chk("R1 reset error", 32'(dec_error), 32'd0);
        rd(8'h00, 32'h0000_0584, "R2 capability word");
        rd(ra(0, 0), 32'd0, "R1 reset ctrl");
        rd(ra(2, 4), 32'd0, "R1 reset size hi");
        rd(ra(3, 1), 32'd0, "R1 reset base lo");
        rd(8'hE0, 32'd0, "R11 unmapped window");
        rd(8'h04, 32'd0, "R11 unmapped cap offset");

        // order: decoder 1 before decoder 0
        wr(ra(1, 3), 32'h100);
        commit(1, cw(0, 0, 0, 1, 0), 0, "R4 out of order");
        rd(ra(1, 0), 32'h0000_0A00, "R4 error ctrl word");
        wr(ra(1, 0), 32'd0);
        chk("R5 release clears error", 32'(dec_error), 32'd0);
        rd(ra(1, 0), 32'd0, "R5 ctrl after release");

        // decoder 0: 2-way, host-only
        wr(ra(0, 2), 32'h1);
        wr(ra(0, 3), 32'h2000);
        commit(0, cw(2, 1, 0, 1, 1), 1, "R3 good commit");
        rd(ra(0, 0), 32'h0000_1612, "R3 committed ctrl word");
        rd(ra(0, 2), 32'h1, "R8 base hi");
        wr(ra(0, 0), cw(2, 3, 0, 1, 0));
        rd(ra(0, 0), 32'h0000_1612, "R10 ctrl fields frozen");

        // zero size
        wr(ra(1, 3), 32'h0);
        commit(1, cw(0, 0, 0, 1, 0), 0, "R6 zero size");
        wr(ra(1, 0), 32'd0);
        // 3-way valid
        wr(ra(1, 3), 32'h3000);
        commit(1, cw(0, 8, 0, 1, 0), 1, "R7 3-way commit");

        // 16-way not advertised
        wr(ra(2, 3), 32'h10000);
        commit(2, cw(0, 4, 0, 1, 0), 0, "R7 16-way unadvertised");
        wr(ra(2, 0), 32'd0);
        wr(ra(2, 3), 32'h1000);
        commit(2, cw(0, 8, 0, 1, 0), 0, "R6 size not multiple of 3");
        wr(ra(2, 0), 32'd0);
        wr(ra(2, 3), 32'h6000);
        commit(2, cw(0, 9, 0, 1, 0), 1, "R7 6-way commit");

        // routing word bytes
        wr(ra(2, 5), 32'h4433_2211);
        wr(ra(2, 6), 32'h8877_6655);
        rd(ra(2, 5), 32'h4433_2211, "R8 target entries 0-3");
        rd(ra(2, 6), 32'h8877_6655, "R8 target entries 4-7");

        // locked decoder 3
        wr(ra(3, 1), 32'h1000);
        wr(ra(3, 3), 32'h400);
        commit(3, cw(0, 2, 1, 1, 0), 1, "R9 locked commit");
        wr(ra(3, 1), 32'hFFFF);
        rd(ra(3, 1), 32'h1000, "R9 base write ignored");
        wr(ra(3, 0), 32'd0);
        chk("R9 release ignored", 32'(dec_committed), 32'hF);
        rd(ra(3, 0), 32'h0000_0720, "R9 ctrl unchanged");

        // release decoder 1
        wr(ra(1, 0), 32'd0);
        chk("R5 release committed", 32'(dec_committed), 32'hD);
        rd(ra(1, 3), 32'h3000, "R5 size kept");
        rd(ra(1, 0), 32'h0000_0080, "R5 fields kept, status clear");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk("R11 reads outstanding", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule